// File: doc/BRIEF.md
# Distributed DRAM Row Refresh Scheduler

This block keeps every row of a DRAM alive by refreshing one row per fixed interval, so the rows are spread evenly across the retention period instead of being refreshed all together in one burst. The interval is a programmable cycle count, set before operation to the retention period divided by the number of rows. For example, a 64 ms retention period and 1024 rows give one refresh every 62.5 us. A free-running interval timer reloads on the same cycle it expires, so the refresh timing does not drift. Each expiry adds one refresh to a saturating backlog. A row pointer chooses the next row, and a small sequencer carries out each refresh. A refresh is a row activation (row strobe low with the row on the address bus), followed by a precharge (row strobe high). The column strobe, write enable and output enable all stay inactive during a refresh.

In normal mode the scheduler raises a request towards the access sequencer and waits for a grant before it takes over the DRAM pins. At all other times the sequencer's own pin values pass straight through. In self-refresh mode the scheduler refreshes from its own timer without any grant, and it ignores the external command and address inputs. When self-refresh is switched off, a refresh that is already running is completed before control goes back to the external interface.

Top module: `refresh_sched`

## Requirements
- R1: The interval timer expires once every `cfg_interval`+1 cycles, counted from reset. It restarts from zero on the same cycle it expires, so expiries keep a fixed period with no drift. If `cfg_interval` is lowered below the current count, the timer expires on the next cycle.
- R2: `ref_req` is high when the backlog is non-zero, self-refresh is off and no refresh is running. If `ref_gnt` is high in such a cycle, a refresh starts on the next clock edge and the backlog drops by one.
- R3: A refresh drives `dram_ras_n` low for `T_RAS` cycles and then high for `T_RP` cycles, with `ref_busy` high for all `T_RAS`+`T_RP` cycles. `dram_cas_n`, `dram_we_n` and `dram_oe_n` stay at 1 throughout.
- R4: `dram_addr` carries the current row for the whole refresh. The row advances by one when a refresh completes. After row `cfg_rows`-1 it wraps to 0, and it stays at 0 when `cfg_rows` is 0 or 1.
- R5: Each timer expiry adds one to the backlog, up to a limit of 8. `urgent` is high exactly while the backlog is 8. An expiry in the same cycle that a refresh starts leaves a full backlog at 8.
- R6: `sr_active` rises one edge after `sr_en` goes high. While it is high and `sr_en` stays high, a pending refresh starts without a grant, and `ref_req` stays low.
- R7: While `sr_active` is high and no refresh is running, all four DRAM strobes are at 1 and `dram_addr` is 0, whatever the external inputs are.
- R8: After `sr_en` goes low, a refresh in progress runs to the end. `sr_active` falls on the first edge at which the sequencer is idle and `sr_en` is low.
- R9: When no refresh is running and `sr_active` is low, every DRAM pin equals its `ext_*` input in the same cycle.
- R10: After reset, the backlog, timer and row are 0, `ref_req`, `ref_busy`, `sr_active` and `urgent` are low, and the pins pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rows | input | ADDR_W+1 | Number of rows to cycle through |
| cfg_interval | input | INTV_W | Refresh interval in cycles, minus one |
| sr_en | input | 1 | Self-refresh request |
| ref_gnt | input | 1 | Grant from the access sequencer |
| ext_ras_n | input | 1 | Row strobe from the access sequencer |
| ext_cas_n | input | 1 | Column strobe from the access sequencer |
| ext_we_n | input | 1 | Write enable from the access sequencer |
| ext_oe_n | input | 1 | Output enable from the access sequencer |
| ext_addr | input | ADDR_W | Address from the access sequencer |
| ref_req | output | 1 | Refresh request to the access sequencer |
| ref_busy | output | 1 | Refresh sequence in progress |
| sr_active | output | 1 | Self-refresh lockout active |
| urgent | output | 1 | Backlog at its limit |
| dram_ras_n | output | 1 | DRAM row strobe |
| dram_cas_n | output | 1 | DRAM column strobe |
| dram_we_n | output | 1 | DRAM write enable |
| dram_oe_n | output | 1 | DRAM output enable |
| dram_addr | output | ADDR_W | DRAM address |

## Verification
Every output is decoded from registers and inputs without further delay. The pass-through pins follow the `ext_*` inputs in the same cycle. `ref_busy` rises and `ref_req` falls on the first edge after a grant, and `sr_active` moves one edge after `sr_en` (on exit, one edge after the sequencer is idle). The backlog, and so `urgent`, changes on the edge at which the timer expires, and the row changes on the edge that ends the precharge. The bench drives its inputs 2 ns after each rising edge and advances an integer reference model on that rising edge. It compares all nine outputs with the model at the following falling edge, so each expected value is checked in the very cycle it becomes due.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACT  = 2'd1,
        SEQ_PRE  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rs_interval_timer.sv
// Free-running interval timer; restarts on the cycle it expires (no drift).
module rs_interval_timer #(
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] cfg_interval,
    output logic              tick
);
    typedef struct packed {
        logic [INTV_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt >= cfg_interval);
        if (tick) s_d.cnt = '0;
        else      s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rs_pending.sv
// Saturating backlog of owed refreshes.
module rs_pending #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pend_any,
    output logic urgent
);
    localparam int PEND_W = $clog2(PEND_MAX + 1);

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
    } pend_s;

    pend_s s_d, s_q;
    logic  inc;

    always_comb begin
        s_d      = s_q;
        pend_any = (s_q.cnt != '0);
        urgent   = (s_q.cnt == PEND_W'(PEND_MAX));
        inc      = tick && (!urgent || take);
        if (inc && !take)      s_d.cnt = s_q.cnt + 1'b1;
        else if (!inc && take) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rs_seq.sv
// Activate/precharge sequencer with the row pointer.
module rs_seq
    import refresh_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int T_RAS  = 4,
    parameter int T_RP   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   cfg_rows,
    output seq_state_e        state,
    output logic [ADDR_W-1:0] row
);
    localparam int PH_MAX = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic [PH_W-1:0]   ph;
        logic [ADDR_W-1:0] row;
    } seq_s;

    seq_s            s_d, s_q;
    logic [ADDR_W:0] row_inc;

    always_comb begin
        s_d     = s_q;
        row_inc = {1'b0, s_q.row} + 1'b1;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.st = SEQ_ACT;
                    s_d.ph = '0;
                end
            end
            SEQ_ACT: begin
                if (s_q.ph == PH_W'(T_RAS - 1)) begin
                    s_d.st = SEQ_PRE;
                    s_d.ph = '0;
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end
            SEQ_PRE: begin
                if (s_q.ph == PH_W'(T_RP - 1)) begin
                    s_d.st  = SEQ_IDLE;
                    s_d.ph  = '0;
                    s_d.row = (row_inc >= cfg_rows) ? '0 : row_inc[ADDR_W-1:0];
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
        state = s_q.st;
        row   = s_q.row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SEQ_IDLE;
            s_q.ph  <= '0;
            s_q.row <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/refresh_sched.sv
// Distributed refresh scheduler top: mode control and DRAM pin steering.
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int INTV_W   = 16,
    parameter int PEND_MAX = 8,
    parameter int T_RAS    = 4,
    parameter int T_RP     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   cfg_rows,
    input  logic [INTV_W-1:0] cfg_interval,
    input  logic              sr_en,
    input  logic              ref_gnt,
    input  logic              ext_ras_n,
    input  logic              ext_cas_n,
    input  logic              ext_we_n,
    input  logic              ext_oe_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              ref_req,
    output logic              ref_busy,
    output logic              sr_active,
    output logic              urgent,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ADDR_W-1:0] dram_addr
);
    typedef struct packed {
        logic sr;
    } top_s;

    top_s              s_d, s_q;
    logic              tick, pend_any, start;
    seq_state_e        st;
    logic [ADDR_W-1:0] row;

    rs_interval_timer #(.INTV_W(INTV_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .tick(tick)
    );

    rs_pending #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(start),
        .pend_any(pend_any), .urgent(urgent)
    );

    rs_seq #(.ADDR_W(ADDR_W), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rows(cfg_rows),
        .state(st), .row(row)
    );

    always_comb begin
        s_d       = s_q;
        ref_busy  = (st != SEQ_IDLE);
        sr_active = s_q.sr;
        start     = !ref_busy && pend_any && (s_q.sr ? sr_en : ref_gnt);
        ref_req   = !ref_busy && pend_any && !s_q.sr;
        if (sr_en)          s_d.sr = 1'b1;
        else if (!ref_busy) s_d.sr = 1'b0;

        if (ref_busy) begin
            dram_ras_n = (st != SEQ_ACT);
            dram_cas_n = 1'b1;
            dram_we_n  = 1'b1;
            dram_oe_n  = 1'b1;
            dram_addr  = row;
        end else if (s_q.sr) begin
            dram_ras_n = 1'b1;
            dram_cas_n = 1'b1;
            dram_we_n  = 1'b1;
            dram_oe_n  = 1'b1;
            dram_addr  = '0;
        end else begin
            dram_ras_n = ext_ras_n;
            dram_cas_n = ext_cas_n;
            dram_we_n  = ext_we_n;
            dram_oe_n  = ext_oe_n;
            dram_addr  = ext_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/refresh_sched_chk.sv
// Port-level properties of the refresh scheduler.
module refresh_sched_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sr_en,
    input logic              ref_gnt,
    input logic              ref_req,
    input logic              ref_busy,
    input logic              sr_active,
    input logic              urgent,
    input logic              dram_ras_n,
    input logic              dram_cas_n,
    input logic              dram_we_n,
    input logic              dram_oe_n,
    input logic [ADDR_W-1:0] dram_addr
);
    // R2: a granted request starts a refresh on the next edge
    assert_grant_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_gnt |=> ref_busy);

    // R3: no column, write or output enable during a refresh
    assert_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> (dram_cas_n && dram_we_n && dram_oe_n));

    // R4: the row address holds steady within a refresh
    assert_row_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy && $past(ref_busy) |-> $stable(dram_addr));

    // R5: a full backlog outside self-refresh is always requested when idle
    assert_urgent_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        urgent && !sr_active && !ref_busy |-> ref_req);

    // R6: no request towards the sequencer during self-refresh
    assert_no_req_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !ref_req);

    // R7: external pins are locked out in self-refresh
    assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active && !ref_busy |->
            (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && dram_addr == '0));

    // R8: exit only from an idle sequencer with the enable low
    assert_clean_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |-> $past(!ref_busy && !sr_en));
endmodule

bind refresh_sched refresh_sched_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_busy(ref_busy), .sr_active(sr_active),
    .urgent(urgent), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
    localparam int ADDR_W = 10;
    localparam int INTV_W = 16;
    localparam int T_RAS  = 4;
    localparam int T_RP   = 3;
    localparam int LIMIT  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W:0]   cfg_rows = 11'd5;
    logic [INTV_W-1:0] cfg_interval = 16'd19;
    logic              sr_en = 1'b0;
    logic              ref_gnt = 1'b0;
    logic              ext_ras_n = 1'b1, ext_cas_n = 1'b1, ext_we_n = 1'b1, ext_oe_n = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              ref_req, ref_busy, sr_active, urgent;
    logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [ADDR_W-1:0] dram_addr;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit checking = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_pend = 0, m_st = 0, m_ph = 0, m_row = 0, m_sr = 0;

    always #10 clk = ~clk;

    refresh_sched #(.ADDR_W(ADDR_W), .INTV_W(INTV_W), .PEND_MAX(LIMIT),
                    .T_RAS(T_RAS), .T_RP(T_RP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_interval(cfg_interval),
        .sr_en(sr_en), .ref_gnt(ref_gnt),
        .ext_ras_n(ext_ras_n), .ext_cas_n(ext_cas_n), .ext_we_n(ext_we_n),
        .ext_oe_n(ext_oe_n), .ext_addr(ext_addr),
        .ref_req(ref_req), .ref_busy(ref_busy), .sr_active(sr_active), .urgent(urgent),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr)
    );

    task automatic cmp(input string tag, input string nm, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, nm, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Model steps on every rising edge, from the inputs held since the previous edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_pend = 0; m_st = 0; m_ph = 0; m_row = 0; m_sr = 0;
        end else begin
            bit tick, start, inc;
            int n_sr;
            tick  = (m_cnt >= int'(cfg_interval));                       // R1
            start = (m_st == 0) && (m_pend > 0) && (m_sr != 0 ? sr_en : ref_gnt); // R2 R6
            n_sr  = sr_en ? 1 : ((m_st == 0) ? 0 : m_sr);                 // R8
            inc   = tick && ((m_pend < LIMIT) || start);                   // R5
            m_pend = m_pend + int'(inc) - int'(start);
            m_cnt  = tick ? 0 : m_cnt + 1;
            case (m_st)
                0: if (start) begin m_st = 1; m_ph = 0; end
                1: if (m_ph == T_RAS - 1) begin m_st = 2; m_ph = 0; end else m_ph++;
                default: if (m_ph == T_RP - 1) begin
                    m_st = 0; m_ph = 0;
                    if (m_row + 1 >= int'(cfg_rows)) m_row = 0; else m_row++;  // R4
                end else m_ph++;
            endcase
            m_sr = n_sr;
        end
        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            finish_run();
        end
    end

    // Compare all outputs at the falling edge.
    always @(negedge clk) begin
        if (checking) begin
            int busy, e_ras, e_cas, e_we, e_oe, e_addr;
            string pin_tag;
            busy = (m_st != 0);
            if (busy) begin
                e_ras = (m_st == 1) ? 0 : 1; e_cas = 1; e_we = 1; e_oe = 1; e_addr = m_row;
                pin_tag = "R3";
            end else if (m_sr != 0) begin
                e_ras = 1; e_cas = 1; e_we = 1; e_oe = 1; e_addr = 0;
                pin_tag = "R7";
            end else begin
                e_ras = ext_ras_n; e_cas = ext_cas_n; e_we = ext_we_n; e_oe = ext_oe_n;
                e_addr = ext_addr;
                pin_tag = "R9";
            end
            cmp("R2", "ref_req", ref_req, (m_sr == 0) && (m_pend > 0) && !busy);
            cmp((m_sr != 0) ? "R6" : "R1", "ref_busy", ref_busy, busy);
            cmp("R8", "sr_active", sr_active, m_sr);
            cmp("R5", "urgent", urgent, m_pend == LIMIT);
            cmp(pin_tag, "dram_ras_n", dram_ras_n, e_ras);
            cmp(pin_tag, "dram_cas_n", dram_cas_n, e_cas);
            cmp(pin_tag, "dram_we_n", dram_we_n, e_we);
            cmp(pin_tag, "dram_oe_n", dram_oe_n, e_oe);
            cmp(busy ? "R4" : pin_tag, "dram_addr", dram_addr, e_addr);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            ext_ras_n = 1'($urandom);
            ext_cas_n = 1'($urandom);
            ext_we_n  = 1'($urandom);
            ext_oe_n  = 1'($urandom);
            ext_addr  = ADDR_W'($urandom);
        end
    endtask

    initial begin
        checking = 1;
        step(3);
        // R10: reset state, checked explicitly while held and after release
        cmp("R10", "ref_busy in reset", ref_busy, 0);
        cmp("R10", "ref_req in reset", ref_req, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        // R1 R2 R3 R4: steady granting, 5 rows wrap several times
        ref_gnt = 1'b1;
        step(320);
        // R5: withhold the grant until the backlog saturates, then drain it
        ref_gnt = 1'b0;
        step(220);
        cmp("R5", "urgent after starvation", urgent, 1);
        ref_gnt = 1'b1;
        step(160);
        // R6 R7: self-refresh without any grant, external pins toggling
        ref_gnt = 1'b0;
        sr_en = 1'b1;
        step(200);
        // R8: drop the enable in the middle of a refresh
        while (!ref_busy) step(1);
        step(2);
        sr_en = 1'b0;
        step(30);
        cmp("R8", "sr_active after exit", sr_active, 0);
        ref_gnt = 1'b1;
        step(60);
        // R1 R5: interval shorter than a refresh, backlog builds despite grants
        cfg_interval = 16'd3;
        step(150);
        // R4: single row and zero rows keep the pointer at 0
        cfg_interval = 16'd9;
        cfg_rows = 11'd1;
        step(100);
        cfg_rows = 11'd0;
        step(60);
        // R1: lower the interval below the running count
        cfg_interval = 16'd40;
        step(30);
        cfg_interval = 16'd2;
        cfg_rows = 11'd3;
        step(80);
        checking = 0;
        finish_run();
    end
endmodule